// File: doc/BRIEF.md
# Carry-Accumulating Interval Stream Decoder

This block turns a compressed stream of timing bytes back into full-width interval values. Each byte arrives on a valid/ready input. A byte whose low seven bits are all zero is a marker. A marker adds a fixed step of 128 to a running carry total and is otherwise absorbed. Any other byte closes an interval. The decoded value is the carry total plus the closing byte's low seven bits. The top bit of the closing byte goes out as a separate flag. After a closing byte the carry total returns to zero.

The block can sit on a readback path behind a capture memory. It can also be placed in a verification environment to rebuild intervals from an encoder's output. A sticky error output reports that the carry total, or an assembled interval, went past the width of the output. In that case the value is clamped to the all-ones code. The output is a single holding register. The input is held off only while an assembled interval waits for a consumer, so with the consumer ready the block takes one byte on every clock.

Top module: `interval_stream_decoder`

## Requirements
- R1: After reset, out_valid and err are 0, in_ready is 1, and the carry total is zero, so a first closing byte b yields an interval of b & 0x7F.
- R2: An accepted byte whose low 7 bits are zero (0x00 or 0x80) adds 128 to the carry total and produces no output; its bit 7 has no effect.
- R3: An accepted byte whose low 7 bits are nonzero produces, on the cycle after it is accepted, out_valid = 1 with out_data equal to the carry total plus the byte's low 7 bits.
- R4: The carry total is zero again after every closing byte, so the next interval counts only markers and bytes that arrive after it.
- R5: out_flag equals bit 7 of the closing byte that produced the interval.
- R6: If a marker would push the carry total above 2^IVAL_W-1, or a closing sum would exceed it, the value clamps to 2^IVAL_W-1 and err goes to 1 and stays at 1 until reset.
- R7: in_ready is 0 exactly when out_valid is 1 and out_ready is 0; while that holds, out_data and out_flag stay unchanged.
- R8: While out_ready is held at 1 and in_valid is held at 1, a byte is accepted on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte this cycle |
| in_byte | input | BYTE_W | Stream byte: flag in the top bit, count in the rest |
| out_valid | output | 1 | Assembled interval available |
| out_ready | input | 1 | Consumer takes the interval this cycle |
| out_data | output | IVAL_W | Assembled interval value |
| out_flag | output | 1 | Flag bit taken from the closing byte |
| err | output | 1 | Sticky overflow indication |

## Verification
The state that is hardest to reach from the ports is carry overflow. With the default 16-bit output it needs 512 back-to-back markers before any closing byte. The stimulus drives exactly that run, alternating 0x00 and 0x80, and then sends a closing byte on top of the clamped total. This exercises both the marker clamp and the sum clamp, and it checks that the error stays set through later clean intervals. A long random phase mixes markers, closing bytes and random consumer stalls, so that closing bytes arrive while an earlier interval is still being held.

// File: rtl/ivd_pkg.sv
package ivd_pkg;

   // Role of one stream byte once its count field is examined
   typedef enum logic {
      BK_CLOSE = 1'b0,
      BK_MARK  = 1'b1
   } byte_kind_e;

   // Decoded view of one stream byte
   typedef struct packed {
      byte_kind_e kind;
      logic       flag;
   } byte_info_t;

endpackage

// File: rtl/ivd_classify.sv
module ivd_classify
   import ivd_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] byte_in,
   output byte_info_t        info,
   output logic [BYTE_W-2:0] count
);

   localparam int CNT_W = BYTE_W - 1;

   generate
      if (BYTE_W < 2) begin : g_bad_width
         $error("ivd_classify: BYTE_W must be at least 2");
      end
   endgenerate

   always_comb begin
      count     = byte_in[CNT_W-1:0];
      info.flag = byte_in[BYTE_W-1];
      info.kind = (count == '0) ? BK_MARK : BK_CLOSE;
   end

endmodule

// File: rtl/ivd_accum.sv
module ivd_accum
   import ivd_pkg::*;
#(
   parameter int IVAL_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  byte_kind_e        kind,
   input  logic [BYTE_W-2:0] count,
   output logic [IVAL_W-1:0] value,
   output logic              err
);

   localparam int CNT_W = BYTE_W - 1;
   localparam int SUM_W = IVAL_W + 1;
   localparam logic [SUM_W-1:0] STEP = SUM_W'(1) << CNT_W;
   localparam logic [IVAL_W-1:0] TOP = '1;

   logic [IVAL_W-1:0] carry_q;
   logic [SUM_W-1:0]  addend;
   logic [SUM_W-1:0]  sum_w;
   logic              ovf;

   generate
      if (IVAL_W <= CNT_W) begin : g_bad_width
         $error("ivd_accum: IVAL_W must exceed the count field width");
      end
   endgenerate

   always_comb begin
      addend = (kind == BK_MARK) ? STEP : SUM_W'(count);
      sum_w  = {1'b0, carry_q} + addend;
      ovf    = sum_w[IVAL_W];
      value  = ovf ? TOP : sum_w[IVAL_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= '0;
         err     <= 1'b0;
      end else if (fire) begin
         if (kind == BK_MARK) begin
            carry_q <= value;
         end else begin
            carry_q <= '0;
         end
         if (ovf) begin
            err <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ivd_outreg.sv
module ivd_outreg #(
   parameter int IVAL_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [IVAL_W-1:0] ld_data,
   input  logic              ld_flag,
   input  logic              take,
   output logic              valid,
   output logic [IVAL_W-1:0] data,
   output logic              flag,
   output logic              stall
);

   assign stall = valid & ~take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
         flag  <= 1'b0;
      end else begin
         if (load) begin
            valid <= 1'b1;
            data  <= ld_data;
            flag  <= ld_flag;
         end else if (take) begin
            valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/interval_stream_decoder.sv
module interval_stream_decoder
   import ivd_pkg::*;
#(
   parameter int IVAL_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BYTE_W-1:0] in_byte,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [IVAL_W-1:0] out_data,
   output logic              out_flag,
   output logic              err
);

   localparam int CNT_W = BYTE_W - 1;

   generate
      if (IVAL_W < 16) begin : g_narrow_out
         $error("interval_stream_decoder: IVAL_W must be at least 16");
      end
   endgenerate

   byte_info_t        info;
   logic [CNT_W-1:0]  count;
   logic              fire;
   logic              stall;
   logic [IVAL_W-1:0] acc_value;

   assign in_ready = ~stall;
   assign fire     = in_valid & in_ready;

   ivd_classify #(.BYTE_W(BYTE_W)) u_classify (
      .byte_in (in_byte),
      .info    (info),
      .count   (count)
   );

   ivd_accum #(.IVAL_W(IVAL_W), .BYTE_W(BYTE_W)) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .kind  (info.kind),
      .count (count),
      .value (acc_value),
      .err   (err)
   );

   ivd_outreg #(.IVAL_W(IVAL_W)) u_outreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (fire & (info.kind == BK_CLOSE)),
      .ld_data (acc_value),
      .ld_flag (info.flag),
      .take    (out_ready),
      .valid   (out_valid),
      .data    (out_data),
      .flag    (out_flag),
      .stall   (stall)
   );

endmodule

// File: rtl/ivd_checker.sv
module ivd_checker #(
   parameter int IVAL_W = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [BYTE_W-1:0] in_byte,
   input logic              out_valid,
   input logic              out_ready,
   input logic [IVAL_W-1:0] out_data,
   input logic              out_flag,
   input logic              err
);

   logic acc_fire;
   logic is_mark;
   assign acc_fire = in_valid && in_ready;
   assign is_mark  = (in_byte[BYTE_W-2:0] == '0);

   // R2: a marker never leaves an interval behind
   a_r2_marker_silent: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fire && is_mark |=> !out_valid);

   // R3: a closing byte is followed by an interval at least as large as its count
   a_r3_close_out: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fire && !is_mark |=> out_valid &&
         (out_data >= IVAL_W'($past(in_byte[BYTE_W-2:0]))));

   // R5: flag follows the closing byte's top bit
   a_r5_flag: assert property (@(posedge clk) disable iff (!rst_n)
      acc_fire && !is_mark |=> out_flag == $past(in_byte[BYTE_W-1]));

   // R6: error is sticky
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R7: a stalled interval holds still
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_flag));

   // R8: an empty output never blocks the input
   a_r8_open: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

endmodule

bind interval_stream_decoder ivd_checker #(.IVAL_W(IVAL_W), .BYTE_W(BYTE_W)) u_ivd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_byte   (in_byte),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_flag  (out_flag),
   .err       (err)
);

// File: tb/interval_stream_decoder_bench.sv
module interval_stream_decoder_bench;

   localparam int CLK_PERIOD = 10;
   localparam int IVAL_W     = 16;
   localparam int BYTE_W     = 8;
   localparam int MAXV       = (1 << IVAL_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [BYTE_W-1:0] in_byte = '0;
   logic              out_valid;
   logic              out_ready = 1'b0;
   logic [IVAL_W-1:0] out_data;
   logic              out_flag;
   logic              err;

   int tests = 0;
   int fails = 0;

   // reference model state
   int m_acc = 0;
   bit m_err = 1'b0;
   int q_val[$];
   bit q_flag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   interval_stream_decoder #(.IVAL_W(IVAL_W), .BYTE_W(BYTE_W)) u_interval_stream_decoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_byte   (in_byte),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_flag  (out_flag),
      .err       (err)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // One clock: drive at the falling edge, compare, then advance the model
   task automatic cyc(input bit v, input logic [7:0] b, input bit r, output bit took);
      bit exp_ready;
      int low;
      int val;
      @(negedge clk);
      in_valid  = v;
      in_byte   = b;
      out_ready = r;
      #1;
      exp_ready = (q_val.size() == 0) || r;
      check("R7", "in_ready", int'(in_ready), int'(exp_ready));
      check("R2", "out_valid", int'(out_valid), int'(q_val.size() != 0));
      if (q_val.size() != 0 && out_valid) begin
         check("R3", "out_data", int'(out_data), q_val[0]);
         check("R5", "out_flag", int'(out_flag), int'(q_flag[0]));
      end
      check("R6", "err", int'(err), int'(m_err));
      took = v && exp_ready;
      if (q_val.size() != 0 && r) begin
         void'(q_val.pop_front());
         void'(q_flag.pop_front());
      end
      if (took) begin
         low = int'(b) & 127;
         if (low == 0) begin
            m_acc += 128;
            if (m_acc > MAXV) begin
               m_acc = MAXV;
               m_err = 1'b1;
            end
         end else begin
            val = m_acc + low;
            if (val > MAXV) begin
               val = MAXV;
               m_err = 1'b1;
            end
            q_val.push_back(val);
            q_flag.push_back(b[7]);
            m_acc = 0;
         end
      end
   endtask

   task automatic send(input logic [7:0] b);
      bit took;
      cyc(1'b1, b, 1'b1, took);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      bit took;
      int acc_cnt;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1", "out_valid in reset", int'(out_valid), 0);
      check("R1", "err in reset", int'(err), 0);
      check("R1", "in_ready in reset", int'(in_ready), 1);
      rst_n = 1'b1;
      // R1: first closing byte sees an empty carry
      send(8'h05);
      send(8'h85);             // R5 flag set
      // R2/R4: markers with both top-bit values
      send(8'h00); send(8'h80); send(8'h03);   // 259
      send(8'h80); send(8'h7F);                // 255, flag 0
      send(8'h00); send(8'h81);                // 129, flag 1
      send(8'h02);                             // R4: back to 2
      cyc(1'b0, 8'h00, 1'b1, took);
      check("R4", "interval after clear", int'(out_data), 2);

      // R7: stall the consumer with input pending
      cyc(1'b1, 8'h11, 1'b0, took);
      cyc(1'b1, 8'h22, 1'b0, took);
      check("R7", "blocked byte not taken", int'(took), 0);
      cyc(1'b1, 8'h33, 1'b0, took);
      cyc(1'b1, 8'h44, 1'b1, took);
      cyc(1'b0, 8'h00, 1'b1, took);

      // R8: full throughput
      acc_cnt = 0;
      for (int i = 0; i < 40; i++) begin
         cyc(1'b1, (i % 3 == 0) ? 8'h00 : 8'(i + 1), 1'b1, took);
         if (took) acc_cnt++;
      end
      check("R8", "bytes accepted in 40 cycles", acc_cnt, 40);

      // Random mix with consumer stalls
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] b;
         b = ($urandom % 3 == 0) ? (($urandom % 2) ? 8'h80 : 8'h00) : 8'($urandom);
         cyc(($urandom % 4) != 0, b, ($urandom % 3) != 0, took);
      end
      cyc(1'b0, 8'h00, 1'b1, took);
      cyc(1'b0, 8'h00, 1'b1, took);

      // R6: carry overflow
      check("R6", "err before overflow", int'(err), 0);
      for (int i = 0; i < 512; i++) begin
         send((i % 2) ? 8'h80 : 8'h00);
      end
      send(8'h01);
      cyc(1'b0, 8'h00, 1'b0, took);
      check("R6", "clamped interval", int'(out_data), MAXV);
      check("R6", "err after overflow", int'(err), 1);
      cyc(1'b0, 8'h00, 1'b1, took);
      send(8'h04);
      cyc(1'b0, 8'h00, 1'b1, took);
      check("R4", "clean interval after overflow", int'(out_data), 4);
      check("R6", "err still set", int'(err), 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule